// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This unit builds the 12-bit byte address used by a small 8-bit controller core for each data memory access and sends the access to the right place. The 4 KiB space is split into sixteen 256-byte pages. An address is formed in one of three ways. In paged direct mode the page register supplies the top nibble. In shared-window direct mode low offsets reach the bottom of page 0 and high offsets reach the top of page 15, whatever the page register holds. In pointer mode a full 12-bit pointer is used as it stands.

Locations from address zero up to a parameterised size are held in an internal single-port RAM. The range F60h to FFFh belongs to the special-function registers, and any access there is handed to an external register port through an address and a read or write strobe. The gap between the RAM and that range is unpopulated: it reads as zero and ignores writes. Reads have one cycle of latency. Only the page register is affected by reset, so the RAM keeps its contents across reset.

Top module: `dmem_addr_unit`

## Requirements
- R1: In paged direct mode (acc_bank_sel=0, acc_indirect=0) the address is {page[3:0], acc_offset}.
- R2: The page register resets to 0. bank_we loads bank_wdata at the clock edge. The new value applies from the next access onward, so an access in the same cycle as the load uses the old value. bank_q shows the register on its low 4 bits, and bits 7:4 always read 0.
- R3: In shared-window mode (acc_bank_sel=1, acc_indirect=0) an offset below 60h maps to 000h+offset and an offset of 60h or more maps to F00h+offset. The page register is ignored.
- R4: In pointer mode (acc_indirect=1) the address is ptr_addr. Both the page register and acc_bank_sel are ignored, and pointer mode wins when both mode bits are set.
- R5: An access whose address is F60h or above raises sfr_rd_stb (read) or sfr_wr_stb (write) in the same cycle, with sfr_addr equal to the address and sfr_wdata equal to acc_wdata. The read data is taken from sfr_rdata one cycle later.
- R6: Addresses below GPR_BYTES (default 2048, so 000h-7FFh) are stored in the internal RAM. A read returns the last value written there, on rd_data in the cycle after the request.
- R7: A read from an address at or above GPR_BYTES and below F60h returns 00h. A write to such an address raises no strobe and changes no RAM location.
- R8: In the cycle after a write or an idle cycle, rd_data is 00h.
- R9: RAM contents are unchanged by reset.
- R10: sfr_rd_stb and sfr_wr_stb are only raised while acc_valid is 1, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the page register only |
| acc_valid | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Operand offset for the direct modes |
| acc_bank_sel | input | 1 | Selects shared-window direct mode |
| acc_indirect | input | 1 | Selects pointer mode |
| ptr_addr | input | 12 | Pointer value used in pointer mode |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the request |
| bank_we | input | 1 | Load the page register |
| bank_wdata | input | 4 | New page number |
| bank_q | output | 8 | Page register, bits 7:4 read 0 |
| sfr_addr | output | 12 | Address presented to the register port |
| sfr_rd_stb | output | 1 | Register port read strobe |
| sfr_wr_stb | output | 1 | Register port write strobe |
| sfr_wdata | output | 8 | Register port write data |
| sfr_rdata | input | 8 | Register port read data, registered by the port |

## Verification
The assertions check on every cycle the properties that depend only on one access: register-port strobes stay inside the register range and are gated by acc_valid; a pointer or high shared-window offset lands on the port unchanged; an unpopulated read or an idle cycle yields zero; and a page load appears on bank_q one cycle later. What only the bench's scenarios can show is storage over time: read-back of earlier RAM writes, that a write into the gap does not alias onto a RAM word, that RAM survives reset, and the ordering in which a page load in the same cycle as an access still uses the old page.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_GPR  = 2'd1,
    RGN_SFR  = 2'd2
  } region_e;

  localparam int ADDR_W_DEF = 12;
  localparam int DATA_W_DEF = 8;

endpackage

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen #(
  parameter int OFF_W     = 8,
  parameter int BANK_W    = 4,
  parameter int ACC_SPLIT = 'h60,
  localparam int ADDR_W   = OFF_W + BANK_W
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic              win_sel,
  input  logic              ptr_sel,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BANK_W-1:0] page,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [OFF_W-1:0]  SPLIT    = OFF_W'(ACC_SPLIT);
  localparam logic [BANK_W-1:0] PAGE_LO  = '0;
  localparam logic [BANK_W-1:0] PAGE_TOP = '1;

  logic [ADDR_W-1:0] paged_addr;
  logic [ADDR_W-1:0] window_addr;

  assign paged_addr = {page, offset};

  always_comb begin
    if (offset < SPLIT) begin
      window_addr = {PAGE_LO, offset};
    end else begin
      window_addr = {PAGE_TOP, offset};
    end
  end

  always_comb begin
    if (ptr_sel) begin
      addr = ptr;
    end else if (win_sel) begin
      addr = window_addr;
    end else begin
      addr = paged_addr;
    end
  end

endmodule

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int GPR_BYTES = 2048,
  parameter int SFR_BASE  = 'hF60
) (
  input  logic              valid,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              ram_we,
  output logic              ram_re,
  output logic              port_rd,
  output logic              port_wr
);

  localparam logic [ADDR_W-1:0] GPR_END = ADDR_W'(GPR_BYTES);
  localparam logic [ADDR_W-1:0] SFR_LO  = ADDR_W'(SFR_BASE);

  always_comb begin
    if (addr >= SFR_LO) begin
      region = RGN_SFR;
    end else if (addr < GPR_END) begin
      region = RGN_GPR;
    end else begin
      region = RGN_NONE;
    end
  end

  always_comb begin
    ram_we  = 1'b0;
    ram_re  = 1'b0;
    port_rd = 1'b0;
    port_wr = 1'b0;
    if (valid) begin
      unique case (region)
        RGN_GPR: begin
          ram_we = we;
          ram_re = ~we;
        end
        RGN_SFR: begin
          port_wr = we;
          port_rd = ~we;
        end
        default: begin
          ram_we = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dmem_gpr_ram.sv
module dmem_gpr_ram #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
    if (re) begin
      q <= mem[idx];
    end
  end

endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
  import dmem_pkg::*;
#(
  parameter int OFF_W     = 8,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8,
  parameter int GPR_BYTES = 2048,
  parameter int SFR_BASE  = 'hF60,
  parameter int ACC_SPLIT = 'h60,
  localparam int ADDR_W   = OFF_W + BANK_W,
  localparam int RAM_IDX_W = $clog2(GPR_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [OFF_W-1:0]  acc_offset,
  input  logic              acc_bank_sel,
  input  logic              acc_indirect,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [DATA_W-1:0] bank_q,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic              sfr_rd_stb,
  output logic              sfr_wr_stb,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);

  logic [BANK_W-1:0] page_r;
  logic [ADDR_W-1:0] eff_addr;
  region_e           region;
  region_e           sel_q;
  logic              ram_we;
  logic              ram_re;
  logic [DATA_W-1:0] ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_r <= '0;
    end else if (bank_we) begin
      page_r <= bank_wdata;
    end
  end

  assign bank_q = {{(DATA_W-BANK_W){1'b0}}, page_r};

  dmem_addr_gen #(
    .OFF_W    (OFF_W),
    .BANK_W   (BANK_W),
    .ACC_SPLIT(ACC_SPLIT)
  ) addr_gen_i (
    .offset (acc_offset),
    .win_sel(acc_bank_sel),
    .ptr_sel(acc_indirect),
    .ptr    (ptr_addr),
    .page   (page_r),
    .addr   (eff_addr)
  );

  dmem_region_dec #(
    .ADDR_W   (ADDR_W),
    .GPR_BYTES(GPR_BYTES),
    .SFR_BASE (SFR_BASE)
  ) region_dec_i (
    .valid  (acc_valid),
    .we     (acc_we),
    .addr   (eff_addr),
    .region (region),
    .ram_we (ram_we),
    .ram_re (ram_re),
    .port_rd(sfr_rd_stb),
    .port_wr(sfr_wr_stb)
  );

  dmem_gpr_ram #(
    .DEPTH (GPR_BYTES),
    .DATA_W(DATA_W)
  ) gpr_ram_i (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .idx  (eff_addr[RAM_IDX_W-1:0]),
    .wdata(acc_wdata),
    .q    (ram_q)
  );

  assign sfr_addr  = eff_addr;
  assign sfr_wdata = acc_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= RGN_NONE;
    end else if (acc_valid && !acc_we) begin
      sel_q <= region;
    end else begin
      sel_q <= RGN_NONE;
    end
  end

  always_comb begin
    unique case (sel_q)
      RGN_GPR: rd_data = ram_q;
      RGN_SFR: rd_data = sfr_rdata;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dmem_addr_unit_chk.sv
module dmem_addr_unit_chk #(
  parameter int OFF_W     = 8,
  parameter int BANK_W    = 4,
  parameter int DATA_W    = 8,
  parameter int GPR_BYTES = 2048,
  parameter int SFR_BASE  = 'hF60,
  parameter int ACC_SPLIT = 'h60,
  localparam int ADDR_W   = OFF_W + BANK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_we,
  input logic [OFF_W-1:0]  acc_offset,
  input logic              acc_bank_sel,
  input logic              acc_indirect,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              bank_we,
  input logic [BANK_W-1:0] bank_wdata,
  input logic [DATA_W-1:0] bank_q,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic              sfr_rd_stb,
  input logic              sfr_wr_stb
);

  localparam logic [ADDR_W-1:0] SFR_LO  = ADDR_W'(SFR_BASE);
  localparam logic [ADDR_W-1:0] GPR_END = ADDR_W'(GPR_BYTES);
  localparam logic [OFF_W-1:0]  SPLIT   = OFF_W'(ACC_SPLIT);

  assert_bank_load_R2: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> bank_q == {{(DATA_W-BANK_W){1'b0}}, $past(bank_wdata)});

  assert_window_high_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_bank_sel && !acc_indirect && acc_offset >= SPLIT
     && {{BANK_W{1'b1}}, acc_offset} >= SFR_LO)
    |-> (sfr_addr == {{BANK_W{1'b1}}, acc_offset}) && (sfr_rd_stb || sfr_wr_stb));

  assert_pointer_route_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_indirect && ptr_addr >= SFR_LO)
    |-> (sfr_addr == ptr_addr) && (acc_we ? sfr_wr_stb : sfr_rd_stb));

  assert_port_range_R5: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd_stb || sfr_wr_stb) |-> sfr_addr >= SFR_LO);

  assert_gap_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_we && acc_indirect && ptr_addr >= GPR_END && ptr_addr < SFR_LO)
    |=> rd_data == '0);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_we) |=> rd_data == '0);

  assert_strobe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !sfr_rd_stb && !sfr_wr_stb);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sfr_rd_stb, sfr_wr_stb}));

endmodule

bind dmem_addr_unit dmem_addr_unit_chk #(
  .OFF_W    (OFF_W),
  .BANK_W   (BANK_W),
  .DATA_W   (DATA_W),
  .GPR_BYTES(GPR_BYTES),
  .SFR_BASE (SFR_BASE),
  .ACC_SPLIT(ACC_SPLIT)
) chk_i (.*);

// File: tb/dmem_addr_unit_tb_top.sv
module dmem_addr_unit_tb_top;

  localparam int GPR_N   = 2048;
  localparam int SFR_LO  = 'hF60;
  localparam int SFR_N   = 4096 - SFR_LO;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_we = 1'b0;
  logic [7:0]  acc_offset = '0;
  logic        acc_bank_sel = 1'b0;
  logic        acc_indirect = 1'b0;
  logic [11:0] ptr_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  rd_data;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_wdata = '0;
  logic [7:0]  bank_q;
  logic [11:0] sfr_addr;
  logic        sfr_rd_stb;
  logic        sfr_wr_stb;
  logic [7:0]  sfr_wdata;
  logic [7:0]  sfr_rdata = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] ref_mem [GPR_N];
  bit         ref_ok  [GPR_N];
  logic [7:0] sfr_dev [SFR_N];
  logic [3:0] page_m = '0;

  always #5 clk = ~clk;

  dmem_addr_unit dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_we(acc_we),
    .acc_offset(acc_offset), .acc_bank_sel(acc_bank_sel),
    .acc_indirect(acc_indirect), .ptr_addr(ptr_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .bank_q(bank_q), .sfr_addr(sfr_addr), .sfr_rd_stb(sfr_rd_stb),
    .sfr_wr_stb(sfr_wr_stb), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // external register file model: registered read
  always @(posedge clk) begin
    if (sfr_wr_stb) sfr_dev[int'(sfr_addr) - SFR_LO] <= sfr_wdata;
    sfr_rdata <= sfr_rd_stb ? sfr_dev[int'(sfr_addr) - SFR_LO] : 8'h00;
  end

  function automatic logic [11:0] f_addr(logic [7:0] off, logic win, logic ind,
                                         logic [11:0] ptr, logic [3:0] pg);
    if (ind) return ptr;
    if (win) return (off < 8'h60) ? {4'h0, off} : {4'hF, off};
    return {pg, off};
  endfunction

  function automatic int f_region(logic [11:0] a);
    if (int'(a) >= SFR_LO) return 2;
    if (int'(a) < GPR_N) return 1;
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(logic [7:0] off, logic win, logic ind, logic [11:0] ptr,
                        logic we, logic [7:0] wd, logic bwe, logic [3:0] bwd);
    logic [11:0] ea;
    int rg;
    string tag;
    logic [7:0] exp_rd;
    bit chk_rd;
    @(negedge clk);
    acc_valid = 1'b1; acc_offset = off; acc_bank_sel = win; acc_indirect = ind;
    ptr_addr = ptr; acc_we = we; acc_wdata = wd; bank_we = bwe; bank_wdata = bwd;
    ea = f_addr(off, win, ind, ptr, page_m);
    rg = f_region(ea);
    tag = ind ? "R4" : (win ? "R3" : "R1");
    #1;
    if (rg == 2) begin
      check({tag, "/R5 port addr"}, sfr_addr, ea);
      check("R5 strobes", {sfr_wr_stb, sfr_rd_stb}, we ? 2'b10 : 2'b01);
      if (we) check("R5 wdata", sfr_wdata, wd);
    end else begin
      check({tag, "/R7 no strobe"}, {sfr_wr_stb, sfr_rd_stb}, 2'b00);
    end
    chk_rd = 1'b1;
    exp_rd = 8'h00;
    if (!we) begin
      if (rg == 1) begin
        chk_rd = ref_ok[ea];
        exp_rd = ref_mem[ea];
      end else if (rg == 2) begin
        exp_rd = sfr_dev[int'(ea) - SFR_LO];
      end
    end else if (rg == 1) begin
      ref_mem[ea] = wd;
      ref_ok[ea] = 1'b1;
    end
    if (bwe) page_m = bwd;
    @(negedge clk);
    acc_valid = 1'b0; bank_we = 1'b0;
    #1;
    if (chk_rd) begin
      if (we) check("R8 zero after write", rd_data, 8'h00);
      else if (rg == 0) check("R7 gap read", rd_data, 8'h00);
      else check({tag, "/R6 read data"}, rd_data, exp_rd);
    end
    if (bwe) check("R2 page load", bank_q, {4'h0, bwd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    for (int i = 0; i < SFR_N; i++) sfr_dev[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < GPR_N; i++) ref_ok[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2 reset page", bank_q, 8'h00);
    check("R8 reset rd_data", rd_data, 8'h00);
    check("R10 idle strobes", {sfr_wr_stb, sfr_rd_stb}, 2'b00);

    // R1 paged direct, page 3
    access(8'h00, 0, 0, 12'h0, 0, 8'h00, 1, 4'h3);
    access(8'h21, 0, 0, 12'h0, 1, 8'hC3, 0, 4'h0);
    access(8'h21, 0, 0, 12'h0, 0, 8'h00, 0, 4'h0);
    // R2 same-cycle load uses old page: reads 0x321, then page 9 is a gap
    access(8'h21, 0, 0, 12'h0, 0, 8'h00, 1, 4'h9);
    access(8'h21, 0, 0, 12'h0, 0, 8'h00, 0, 4'h0);
    // R3 window: low offset hits page 0, high offset hits the register range
    access(8'h5F, 1, 0, 12'h0, 1, 8'h77, 0, 4'h0);
    access(8'h5F, 1, 0, 12'h0, 0, 8'h00, 0, 4'h0);
    access(8'h60, 1, 0, 12'h0, 1, 8'h3C, 0, 4'h0);
    access(8'h60, 1, 0, 12'h0, 0, 8'h00, 0, 4'h0);
    access(8'hFF, 1, 0, 12'h0, 0, 8'h00, 0, 4'h0);
    // R4 pointer overrides both mode bit and page
    access(8'h00, 1, 1, 12'h7FF, 1, 8'hE1, 0, 4'h0);
    access(8'h00, 1, 1, 12'h7FF, 0, 8'h00, 0, 4'h0);
    access(8'h00, 0, 1, 12'hF60, 0, 8'h00, 0, 4'h0);
    // R7 gap edges and no aliasing onto RAM
    access(8'h00, 0, 1, 12'h123, 1, 8'h99, 0, 4'h0);
    access(8'h00, 0, 1, 12'h923, 1, 8'h44, 0, 4'h0);
    access(8'h00, 0, 1, 12'h123, 0, 8'h00, 0, 4'h0);
    access(8'h00, 0, 1, 12'h800, 0, 8'h00, 0, 4'h0);
    access(8'h00, 0, 1, 12'hF5F, 0, 8'h00, 0, 4'h0);
    // R9 RAM survives reset, page does not
    access(8'h00, 0, 1, 12'h055, 1, 8'hA7, 1, 4'h6);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0; page_m = 4'h0;
    #1;
    check("R2 page cleared by reset", bank_q, 8'h00);
    access(8'h00, 0, 1, 12'h055, 0, 8'h00, 0, 4'h0);
    check("R9 value kept", ref_mem[12'h055], 8'hA7);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] p;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 5)      p = 12'($urandom_range(0, GPR_N - 1));
      else if (sel < 8) p = 12'($urandom_range(SFR_LO, 4095));
      else              p = 12'($urandom_range(GPR_N, SFR_LO - 1));
      access(8'($urandom), 1'($urandom), 1'($urandom_range(0, 2) == 0), p,
             1'($urandom), 8'($urandom), 1'($urandom_range(0, 9) == 0),
             4'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule